// File: doc/BRIEF.md
# Disk Arm Seek and Recalibration Sequencer

This block moves a stepper-driven disk arm onto a requested cylinder before a transfer begins. A request carries a target cylinder and a flag that marks a fixed-head address. The block compares the target with the cylinder it remembers and writes step commands to the drive-control register, one command per cylinder of travel. It then waits for the drive to report that the seek has finished and lets the heads settle before it reports done. Every wait that depends on the disk is counted in sector wakeups, which are single-cycle pulses that arrive once per passing sector.

When the remembered cylinder reads all ones, the arm position is unknown. The block then recalibrates first. It walks the arm toward cylinder zero one track at a time and waits for each step to complete before it looks at the track-zero status bit. If track zero never appears within a step budget, the block gives up and reports an error. If the arm has to turn around and travel outward after reaching track zero, the block first pauses for a programmed number of wakeups. This spares the stepper from an abrupt change of direction.

The block comes out of reset in the uncalibrated state. It takes a request only while it is idle and ends every accepted request with exactly one single-cycle result pulse: done, seek timeout or recalibration error.

Top module: `arm_positioner`

## Requirements
- R1: After reset, `cur_cyl` is all ones (uncalibrated), `busy` is low, and `cmd_vld`, `done`, `seek_tmo` and `recal_err` are low.
- R2: A request accepted while `cur_cyl` is all ones first recalibrates. The block issues step commands with `cmd_dir`=0 (toward lower cylinders) until `trk0` is seen high, then sets `cur_cyl` to 0.
- R3: During recalibration, each step is released and followed by a wait for `seek_cmp`, sampled on a `sec_wake` pulse, before `trk0` is examined and another step is written.
- R4: If `trk0` is still low after RECAL_LIMIT recalibration steps, the block pulses `recal_err`, writes no further step, and leaves `cur_cyl` all ones.
- R5: When track zero is reached and the target is nonzero, the first outward step is written only after PAUSE_WAKES further `sec_wake` pulses beyond the one that reported `seek_cmp`.
- R6: A seek writes exactly |target − current| step commands (`cmd_step`=1). `cmd_dir`=1 means toward higher cylinders and is used when target > current.
- R7: Any two consecutive command writes (`cmd_vld` pulses) are at least STEP_GAP clock cycles apart.
- R8: After the last step, one more command is written with `cmd_step`=0, `cmd_dir` equal to the direction of the steps, and `cmd_wake`=1.
- R9: If `seek_cmp` is low on SEEK_TMO_WAKES consecutive `sec_wake` pulses after the release command, the block pulses `seek_tmo` on the last of them and leaves `cur_cyl` unchanged.
- R10: After a `sec_wake` that sees `seek_cmp` high, `done` pulses on the SETTLE_WAKES-th following `sec_wake`, and `cur_cyl` takes the target value at that moment.
- R11: A request with `req_fixed`=1 on a calibrated arm writes no step, pulses `done`, and leaves `cur_cyl` unchanged, even when the cylinders differ.
- R12: A request whose target equals `cur_cyl` writes no step and pulses `done`.
- R13: Each accepted request ends with exactly one single-cycle result pulse, and a `req` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request pulse, taken only while idle |
| req_cyl | input | CYL_W | Target cylinder |
| req_fixed | input | 1 | Target is a fixed-head address; no arm motion needed |
| sec_wake | input | 1 | Sector wakeup pulse |
| trk0 | input | 1 | Drive status: arm at track zero |
| seek_cmp | input | 1 | Drive status: seek complete |
| cmd_vld | output | 1 | Command write strobe to the drive-control register |
| cmd_step | output | 1 | Step bit of the command word |
| cmd_dir | output | 1 | Direction bit: 1 toward higher cylinders |
| cmd_wake | output | 1 | Wakeup-enable bit of the command word |
| cur_cyl | output | CYL_W | Remembered arm cylinder; all ones when uncalibrated |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Arm positioned (pulse) |
| seek_tmo | output | 1 | Seek completion never arrived (pulse) |
| recal_err | output | 1 | Track zero never reached (pulse) |

## Verification
The stimulus mixes directed cases with random ones. A random case draws a target, an initial arm position hidden from the block, a delay from release to seek-complete, and occasionally a fixed-head flag, a missing seek-complete, or a reset that throws away calibration. Requests from an unknown position separate a recalibration from a direct seek. An outward target after recalibration exposes the reversal pause, which a target of zero does not. A drive that never shows track zero tests the step budget. Targets above, below and equal to the current cylinder, together with fixed-head requests, check the step count and direction. Varying the seek-complete delay moves the settle and timeout windows, so an off-by-one in any wakeup count shows up as a wrong wakeup index for the result pulse.

// File: rtl/arm_pkg.sv
package arm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCHK,
    ST_EVAL,
    ST_STEP,
    ST_REL,
    ST_WAIT,
    ST_PAUSE,
    ST_SETTLE
  } arm_state_t;
endpackage

// File: rtl/arm_downcount.sv
module arm_downcount #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (load)                 count <= load_val;
    else if (tick && count != '0)  count <= count - 1'b1;
  end
endmodule

// File: rtl/arm_cmd_port.sv
module arm_cmd_port #(
  parameter int STEP_GAP = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic issue_step,
  input  logic issue_dir,
  output logic gap_ok,
  output logic cmd_vld,
  output logic cmd_step,
  output logic cmd_dir,
  output logic cmd_wake
);
  localparam int GW = $clog2(STEP_GAP + 1);

  logic [GW-1:0] gap_cnt;

  arm_downcount #(.W(GW)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (issue),
    .load_val (GW'(STEP_GAP - 1)),
    .tick     (1'b1),
    .count    (gap_cnt)
  );

  assign gap_ok = (gap_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_vld  <= 1'b0;
      cmd_step <= 1'b0;
      cmd_dir  <= 1'b0;
      cmd_wake <= 1'b0;
    end else begin
      cmd_vld <= issue;
      if (issue) begin
        cmd_step <= issue_step;
        cmd_dir  <= issue_dir;
        cmd_wake <= 1'b1;
      end
    end
  end

  // Spacing monitor: cycles since the previous command write
  logic [GW:0] since_q;
  logic        seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (cmd_vld) begin
      since_q <= (GW+1)'(1);
      seen_q  <= 1'b1;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && seen_q) |-> (int'(since_q) >= STEP_GAP)); // R7
endmodule

// File: rtl/arm_positioner.sv
module arm_positioner
  import arm_pkg::*;
#(
  parameter int CYL_W          = 10,
  parameter int STEP_GAP       = 50,
  parameter int SETTLE_WAKES   = 8,
  parameter int PAUSE_WAKES    = 24,
  parameter int SEEK_TMO_WAKES = 40,
  parameter int RECAL_LIMIT    = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CYL_W-1:0] req_cyl,
  input  logic             req_fixed,
  input  logic             sec_wake,
  input  logic             trk0,
  input  logic             seek_cmp,
  output logic             cmd_vld,
  output logic             cmd_step,
  output logic             cmd_dir,
  output logic             cmd_wake,
  output logic [CYL_W-1:0] cur_cyl,
  output logic             busy,
  output logic             done,
  output logic             seek_tmo,
  output logic             recal_err
);
  localparam int WK_A   = (SETTLE_WAKES > PAUSE_WAKES) ? SETTLE_WAKES : PAUSE_WAKES;
  localparam int WK_MAX = (WK_A > SEEK_TMO_WAKES) ? WK_A : SEEK_TMO_WAKES;
  localparam int WK_W   = $clog2(WK_MAX + 1);
  localparam int RB_W   = $clog2(RECAL_LIMIT + 1);
  localparam logic [CYL_W-1:0] UNCAL = '1;

  arm_state_t       state_q, st_d;
  logic [CYL_W-1:0] tgt_q, cur_q, dist_q;
  logic             fixed_q, dir_q, recal_q;
  logic [RB_W-1:0]  rb_q;

  logic             issue, iss_step, gap_ok;
  logic             wk_load, wk_tick;
  logic [WK_W-1:0]  wk_val, wk_cnt;
  logic             done_d, tmo_d, err_d;
  logic             latch_req, start_recal, cur_zero, cur_tgt;
  logic             rb_inc, seek_setup, dist_dec;

  arm_downcount #(.W(WK_W)) u_wake_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wk_load),
    .load_val (wk_val),
    .tick     (wk_tick),
    .count    (wk_cnt)
  );

  arm_cmd_port #(.STEP_GAP(STEP_GAP)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_step (iss_step),
    .issue_dir  (dir_q),
    .gap_ok     (gap_ok),
    .cmd_vld    (cmd_vld),
    .cmd_step   (cmd_step),
    .cmd_dir    (cmd_dir),
    .cmd_wake   (cmd_wake)
  );

  wire last_wake = (wk_cnt == WK_W'(1));

  always_comb begin
    st_d        = state_q;
    issue       = 1'b0;
    iss_step    = 1'b0;
    wk_load     = 1'b0;
    wk_val      = '0;
    wk_tick     = 1'b0;
    done_d      = 1'b0;
    tmo_d       = 1'b0;
    err_d       = 1'b0;
    latch_req   = 1'b0;
    start_recal = 1'b0;
    cur_zero    = 1'b0;
    cur_tgt     = 1'b0;
    rb_inc      = 1'b0;
    seek_setup  = 1'b0;
    dist_dec    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        latch_req   = 1'b1;
        start_recal = (cur_q == UNCAL);
        st_d        = (cur_q == UNCAL) ? ST_RCHK : ST_EVAL;
      end
      ST_RCHK: begin
        if (trk0) begin
          cur_zero = 1'b1;
          wk_load  = 1'b1;
          if (tgt_q == '0) begin
            wk_val = WK_W'(SETTLE_WAKES);
            st_d   = ST_SETTLE;
          end else begin
            wk_val = WK_W'(PAUSE_WAKES);
            st_d   = ST_PAUSE;
          end
        end else if (rb_q == RB_W'(RECAL_LIMIT)) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          rb_inc = 1'b1;
          st_d   = ST_STEP;
        end
      end
      ST_EVAL: begin
        if (fixed_q || tgt_q == cur_q) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          seek_setup = 1'b1;
          st_d       = ST_STEP;
        end
      end
      ST_STEP: if (gap_ok) begin
        issue    = 1'b1;
        iss_step = 1'b1;
        dist_dec = 1'b1;
        if (dist_q == CYL_W'(1)) st_d = ST_REL;
      end
      ST_REL: if (gap_ok) begin
        issue   = 1'b1;
        wk_load = 1'b1;
        wk_val  = WK_W'(SEEK_TMO_WAKES);
        st_d    = ST_WAIT;
      end
      ST_WAIT: if (sec_wake) begin
        if (seek_cmp) begin
          if (recal_q) begin
            st_d = ST_RCHK;
          end else begin
            wk_load = 1'b1;
            wk_val  = WK_W'(SETTLE_WAKES);
            st_d    = ST_SETTLE;
          end
        end else if (last_wake) begin
          tmo_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          wk_tick = 1'b1;
        end
      end
      ST_PAUSE: if (sec_wake) begin
        if (last_wake) st_d = ST_EVAL;
        else           wk_tick = 1'b1;
      end
      ST_SETTLE: if (sec_wake) begin
        if (last_wake) begin
          cur_tgt = 1'b1;
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          wk_tick = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      tgt_q     <= '0;
      fixed_q   <= 1'b0;
      cur_q     <= UNCAL;
      dist_q    <= '0;
      dir_q     <= 1'b0;
      recal_q   <= 1'b0;
      rb_q      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      seek_tmo  <= 1'b0;
      recal_err <= 1'b0;
    end else begin
      state_q   <= st_d;
      busy      <= (st_d != ST_IDLE);
      done      <= done_d;
      seek_tmo  <= tmo_d;
      recal_err <= err_d;
      if (latch_req) begin
        tgt_q   <= req_cyl;
        fixed_q <= req_fixed;
      end
      if (start_recal) begin
        recal_q <= 1'b1;
        rb_q    <= '0;
      end
      if (cur_zero) begin
        cur_q   <= '0;
        recal_q <= 1'b0;
      end
      if (cur_tgt) cur_q <= tgt_q;
      if (rb_inc) begin
        rb_q   <= rb_q + 1'b1;
        dist_q <= CYL_W'(1);
        dir_q  <= 1'b0;
      end
      if (seek_setup) begin
        dir_q  <= (tgt_q > cur_q);
        dist_q <= (tgt_q > cur_q) ? (tgt_q - cur_q) : (cur_q - tgt_q);
      end
      if (dist_dec) dist_q <= dist_q - 1'b1;
    end
  end

  assign cur_cyl = cur_q;

  // Direction of the most recent step command, for the release check
  logic last_dir_q;
  always_ff @(posedge clk) begin
    if (rst)                      last_dir_q <= 1'b0;
    else if (cmd_vld && cmd_step) last_dir_q <= cmd_dir;
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, seek_tmo, recal_err})); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R13
  AST_RECAL_INWARD: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_step && recal_q) |-> !cmd_dir); // R2
  AST_RELEASE_DIR: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && !cmd_step) |-> (cmd_dir == last_dir_q && cmd_wake)); // R8
  AST_RECAL_BUDGET: assert property (@(posedge clk) disable iff (rst)
    recal_q |-> (int'(rb_q) <= RECAL_LIMIT)); // R4
  AST_CUR_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_q) |-> ($past(state_q) == ST_SETTLE || $past(state_q) == ST_RCHK)); // R10
endmodule

// File: tb/tb_arm_positioner.sv
module tb_arm_positioner;
  localparam int CLK_PERIOD = 10;
  localparam int CYL_W      = 8;
  localparam int GAP        = 8;
  localparam int SETTLE     = 3;
  localparam int PAUSE      = 5;
  localparam int TMO        = 4;
  localparam int LIMIT      = 300;
  localparam int WAKE_PER   = 8;
  localparam logic [CYL_W-1:0] ONES = '1;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, req_fixed = 1'b0;
  logic [CYL_W-1:0] req_cyl = '0;
  logic sec_wake = 1'b0, trk0 = 1'b0, seek_cmp = 1'b0;
  logic cmd_vld, cmd_step, cmd_dir, cmd_wake, busy, done, seek_tmo, recal_err;
  logic [CYL_W-1:0] cur_cyl;

  always #(CLK_PERIOD/2) clk = ~clk;

  arm_positioner #(.CYL_W(CYL_W), .STEP_GAP(GAP), .SETTLE_WAKES(SETTLE),
    .PAUSE_WAKES(PAUSE), .SEEK_TMO_WAKES(TMO), .RECAL_LIMIT(LIMIT)) dut (
    .clk(clk), .rst(rst), .req(req), .req_cyl(req_cyl), .req_fixed(req_fixed),
    .sec_wake(sec_wake), .trk0(trk0), .seek_cmp(seek_cmp),
    .cmd_vld(cmd_vld), .cmd_step(cmd_step), .cmd_dir(cmd_dir), .cmd_wake(cmd_wake),
    .cur_cyl(cur_cyl), .busy(busy), .done(done), .seek_tmo(seek_tmo), .recal_err(recal_err));

  int checks = 0, failures = 0;
  // drive model state
  int arm = 0, kd = 1, wsr = 0, cyc = 0, last_cmd_cyc = 0;
  bit stuck = 0, rel_any = 0, have_cmd = 0, prev_term = 0, last_dir = 0;
  int in_steps, out_steps, term_cnt, fin, fin_wsr, first_out_wsr;
  int gap_bad, rel_bad, wait_bad, pulse_bad;
  logic [CYL_W-1:0] cur_e = ONES;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive model, samples registered outputs and drives status at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (done || seek_tmo || recal_err) begin
        term_cnt++;
        if (prev_term) pulse_bad++;
        fin     = done ? 1 : (seek_tmo ? 2 : 3);
        fin_wsr = wsr;
      end
      prev_term = done || seek_tmo || recal_err;
      if (cmd_vld) begin
        if (have_cmd && (cyc - last_cmd_cyc) < GAP) gap_bad++;
        have_cmd = 1;
        last_cmd_cyc = cyc;
        if (cmd_step) begin
          if (rel_any && wsr < kd) wait_bad++;
          if (cmd_dir) begin
            if (out_steps == 0) first_out_wsr = wsr;
            out_steps++;
            arm++;
          end else begin
            in_steps++;
            if (arm != 0) arm--;
          end
          last_dir = cmd_dir;
        end else begin
          if (cmd_dir != last_dir || !cmd_wake) rel_bad++;
          rel_any  = 1;
          wsr      = 0;
          seek_cmp = 1'b0;
        end
      end
      trk0 = (arm == 0) && !stuck;
    end
    sec_wake = ((cyc % WAKE_PER) == 0);
    if (sec_wake) begin
      wsr++;
      if (kd != 0 && rel_any && wsr >= kd) seek_cmp = 1'b1;
    end
  end

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Expected outcome: result code 1 done, 2 timeout, 3 recal error
  function automatic void predict(input logic [CYL_W-1:0] c, input int a, input bit stk,
      input int t, input bit fx, input int k,
      output int e_in, output int e_out, output int e_res, output logic [CYL_W-1:0] e_cur);
    int cc;
    e_in = 0; e_out = 0; e_res = 1; e_cur = c;
    cc = int'(c);
    if (c == ONES) begin
      if (stk) begin e_in = LIMIT; e_res = 3; return; end
      e_in = a; cc = 0; e_cur = '0;
      if (t == 0 || fx) return;
    end else if (fx || t == cc) return;
    if (t > cc) e_out = t - cc; else e_in = e_in + (cc - t);
    if (k == 0) e_res = 2;
    else e_cur = CYL_W'(t);
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset(input int a, input bit stk);
    rst = 1'b1; arm = a; stuck = stk; tick(3);
    rst = 1'b0; cur_e = ONES; tick(2);
    chk(cur_cyl == ONES && !busy && !done && !seek_tmo && !recal_err && !cmd_vld,
        "R1 reset state", int'(cur_cyl), int'(ONES));
  endtask

  task automatic run_req(input int t, input bit fx, input int k, input bit poke, input int t2);
    int e_in, e_out, e_res, wd;
    logic [CYL_W-1:0] e_cur;
    bit was_recal;
    was_recal = (cur_e == ONES);
    predict(cur_e, arm, stuck, t, fx, k, e_in, e_out, e_res, e_cur);
    kd = k; rel_any = 0; in_steps = 0; out_steps = 0; term_cnt = 0; fin = 0;
    gap_bad = 0; rel_bad = 0; wait_bad = 0; pulse_bad = 0; first_out_wsr = -1; have_cmd = 0;
    req_cyl = CYL_W'(t); req_fixed = fx; req = 1'b1; tick(1); req = 1'b0;
    if (poke) begin
      tick(3);
      req_cyl = CYL_W'(t2); req_fixed = 1'b0; req = 1'b1; tick(1); req = 1'b0;
    end
    wd = 0;
    while (fin == 0 && wd < 50000) begin tick(1); wd++; end
    if (fin == 0) begin
      checks++; failures++;
      $display("FAIL R13 watchdog actual=%0d expected=%0d", 0, e_res);
    end
    tick(4);
    chk(fin == e_res, "R13 result kind", fin, e_res);
    chk(term_cnt == 1 && pulse_bad == 0, "R13 one single-cycle result", term_cnt, 1);
    chk(in_steps == e_in, "R2/R6 inward steps", in_steps, e_in);
    chk(out_steps == e_out, "R6 outward steps", out_steps, e_out);
    chk(cur_cyl == e_cur, "R10 current cylinder", int'(cur_cyl), int'(e_cur));
    chk(gap_bad == 0, "R7 command spacing", gap_bad, 0);
    chk(rel_bad == 0, "R8 release command", rel_bad, 0);
    chk(wait_bad == 0, "R3 step before seek complete", wait_bad, 0);
    if (e_in + e_out > 0) begin
      if (e_res == 1) chk(fin_wsr == k + SETTLE, "R10 settle wakeups", fin_wsr, k + SETTLE);
      if (e_res == 2) chk(fin_wsr == TMO, "R9 timeout wakeups", fin_wsr, TMO);
      if (e_res == 3) chk(fin_wsr == k, "R4 give-up point", fin_wsr, k);
    end
    if (was_recal && e_in > 0 && e_out > 0)
      chk(first_out_wsr == k + PAUSE, "R5 reversal pause", first_out_wsr, k + PAUSE);
    cur_e = e_cur;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    tick(1);
    do_reset(7, 0);                       // R1
    run_req(0, 0, 2, 0, 0);               // R2 R3 recalibrate to zero
    run_req(12, 0, 1, 0, 0);              // R6 R7 R8 outward seek
    run_req(12, 0, 1, 0, 0);              // R12 same cylinder
    run_req(3, 1, 1, 0, 0);               // R11 fixed head
    run_req(5, 0, 0, 0, 0);               // R9 timeout, cur stays 12
    run_req(20, 0, 2, 1, 2);              // R13 second request ignored
    run_req(4, 0, 3, 0, 0);               // R6 inward seek
    do_reset(9, 0);
    run_req(15, 0, 1, 0, 0);              // R5 recal then pause then outward
    do_reset(4, 1);
    run_req(3, 0, 1, 0, 0);               // R4 recal budget exhausted
    stuck = 0;
    run_req(6, 0, 2, 0, 0);               // R2 recal with arm already at zero
    for (int i = 0; i < 25; i++) begin
      int t, k;
      bit fx;
      if ($urandom % 6 == 0) do_reset(int'($urandom % 41), 0);
      t  = int'($urandom % 61);
      fx = (cur_e != ONES) && ($urandom % 6 == 0);
      k  = 1 + int'($urandom % 3);
      if (cur_e != ONES && !fx && CYL_W'(t) != cur_e && $urandom % 7 == 0) k = 0;
      run_req(t, fx, k, 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule